// File: doc/BRIEF.md
# 32-bit Integer ALU with Zero Flag

This block is the combinational arithmetic and logic stage of a small RISC-V style integer datapath. It receives two 32-bit operands and a 4-bit operation code and returns a 32-bit result. Alongside the result it returns a flag that reports an all-zero result, which branch logic further down the pipe can use.

Inside the block there are four units. A bitwise unit handles AND, OR and XOR. One adder serves both addition and subtraction and also produces the sign and signed-overflow terms. Three shifters cover logical left, logical right and arithmetic right. A signed less-than stage is derived from the subtractor's sign and overflow. A final selector routes one unit to the output. For shifts, operand B is the value that moves and the low five bits of operand A give the distance. The block has no clock, no reset and no state.

Top module: `rv_alu`

## Requirements
- R1: Code 0000 gives A AND B, code 0001 gives A OR B, and code 0011 gives A XOR B, each bit by bit.
- R2: Code 0010 gives A + B modulo 2^32.
- R3: Code 0110 gives A - B modulo 2^32, formed as A plus the inverted B plus one on the same adder used for code 0010.
- R4: Code 0111 gives 0x00000001 when A is less than B as signed two's-complement numbers and 0x00000000 otherwise. The answer stays correct when A - B overflows.
- R5: Code 0100 shifts B left by A[4:0] and fills with zeros. Bits A[31:5] have no effect.
- R6: Code 0101 shifts B right by A[4:0] and fills with zeros. Bits A[31:5] have no effect.
- R7: Code 1000 shifts B right by A[4:0] and fills the vacated upper bits with B[31].
- R8: In all three shift codes, a shift amount A[4:0] of 0 returns B unchanged.
- R9: Codes 1001 through 1111 give a result of 0x00000000, so the zero flag is 1.
- R10: The zero flag is 1 exactly when the 32-bit result is 0x00000000, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; its low five bits are the shift distance for shift codes |
| op_b | input | 32 | Second operand; this is the value that moves for shift codes |
| alu_op | input | 4 | Operation code |
| alu_result | output | 32 | Selected result |
| result_zero | output | 1 | High when alu_result is all zeros |

## Verification
The zero flag and the selected operation settle in the same evaluation. They are checked together on every applied vector, with the flag judged against the reference result rather than against the design's own output. The stimulus deliberately drives results to zero through other operations: A - A, equal operands for less-than, an AND of disjoint masks, and a left shift of 31 applied to a value whose low bit is clear. This shows that the flag follows the chosen source and not only the adder. The less-than stage and signed overflow also meet in one cycle: operand pairs at the extremes of the signed range (0x80000000 against 1, 0x7FFFFFFF against 0xFFFFFFFF) force A - B to overflow, and the one-bit answer is compared with a plain signed comparison.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_AND = 4'b0000,
      OPC_OR  = 4'b0001,
      OPC_ADD = 4'b0010,
      OPC_XOR = 4'b0011,
      OPC_SLL = 4'b0100,
      OPC_SRL = 4'b0101,
      OPC_SUB = 4'b0110,
      OPC_SLT = 4'b0111,
      OPC_SRA = 4'b1000
   } alu_opc_e;

   typedef enum logic [1:0] {
      BIT_AND = 2'd0,
      BIT_OR  = 2'd1,
      BIT_XOR = 2'd2
   } bit_fn_e;

   typedef enum logic [2:0] {
      SRC_ARITH = 3'd0,
      SRC_LESS  = 3'd1,
      SRC_SHIFT = 3'd2,
      SRC_BITS  = 3'd3,
      SRC_NONE  = 3'd4
   } res_src_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } sh_kind_e;

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import rv_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  bit_fn_e      fn,
   output logic [W-1:0] z
);
   always_comb begin
      unique case (fn)
         BIT_AND: z = x & y;
         BIT_OR:  z = x | y;
         BIT_XOR: z = x ^ y;
         default: z = '0;
      endcase
   end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         do_sub,
   output logic [W-1:0] sum,
   output logic         neg,
   output logic         ovf
);
   logic [W-1:0] y_eff;
   logic [W-1:0] carry_in;

   always_comb begin
      y_eff    = y ^ {W{do_sub}};
      carry_in = {{(W-1){1'b0}}, do_sub};
      sum      = x + y_eff + carry_in;
      neg      = sum[W-1];
      ovf      = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W      = 32,
   parameter int AMT_W  = 5,
   parameter bit LEFT   = 1'b0,
   parameter bit ARITH  = 1'b0,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     dout
);
   generate
      if (LEFT && ARITH) begin : g_bad_cfg
         $error("alu_shifter: arithmetic fill applies to right shifts only");
      end

      if (STAGED) begin : g_staged
         logic [W-1:0] stg [0:AMT_W];
         logic         fill;
         assign fill   = ARITH ? din[W-1] : 1'b0;
         assign stg[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            logic [W-1:0] moved;
            if (LEFT) begin : g_l
               assign moved = {stg[k][W-1-STEP:0], {STEP{1'b0}}};
            end else begin : g_r
               assign moved = {{STEP{fill}}, stg[k][W-1:STEP]};
            end
            assign stg[k+1] = amt[k] ? moved : stg[k];
         end
         assign dout = stg[AMT_W];
      end else begin : g_operator
         if (LEFT) begin : g_l
            assign dout = din << amt;
         end else if (ARITH) begin : g_ra
            assign dout = W'($signed(din) >>> amt);
         end else begin : g_rl
            assign dout = din >> amt;
         end
      end
   endgenerate
endmodule

// File: rtl/rv_alu.sv
module rv_alu
   import rv_alu_pkg::*;
#(
   parameter int W            = 32,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   input  logic [OPC_W-1:0] alu_op,
   output logic [W-1:0]     alu_result,
   output logic             result_zero
);
   localparam int AMT_W = $clog2(W);

   generate
      if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
         $error("rv_alu: W must be a power of two of at least 8");
      end
   endgenerate

   alu_opc_e     opc;
   res_src_e     src;
   bit_fn_e      bfn;
   sh_kind_e     skind;
   logic         sub_en;

   logic [W-1:0] bits_out;
   logic [W-1:0] arith_out;
   logic         arith_neg;
   logic         arith_ovf;
   logic [W-1:0] less_out;
   logic [W-1:0] sh_left;
   logic [W-1:0] sh_rlog;
   logic [W-1:0] sh_rari;
   logic [W-1:0] sh_out;

   // Operation decode into the internal unit controls.
   always_comb begin
      opc    = alu_opc_e'(alu_op);
      src    = SRC_NONE;
      bfn    = BIT_AND;
      skind  = SH_LEFT;
      sub_en = 1'b0;
      case (opc)
         OPC_AND: begin src = SRC_BITS;  bfn = BIT_AND; end
         OPC_OR:  begin src = SRC_BITS;  bfn = BIT_OR;  end
         OPC_XOR: begin src = SRC_BITS;  bfn = BIT_XOR; end
         OPC_ADD: begin src = SRC_ARITH; end
         OPC_SUB: begin src = SRC_ARITH; sub_en = 1'b1; end
         OPC_SLT: begin src = SRC_LESS;  sub_en = 1'b1; end
         OPC_SLL: begin src = SRC_SHIFT; skind = SH_LEFT; end
         OPC_SRL: begin src = SRC_SHIFT; skind = SH_RLOG; end
         OPC_SRA: begin src = SRC_SHIFT; skind = SH_RARI; end
         default: src = SRC_NONE;
      endcase
   end

   alu_bitwise #(.W(W)) u_bits (
      .x  (op_a),
      .y  (op_b),
      .fn (bfn),
      .z  (bits_out)
   );

   alu_addsub #(.W(W)) u_arith (
      .x      (op_a),
      .y      (op_b),
      .do_sub (sub_en),
      .sum    (arith_out),
      .neg    (arith_neg),
      .ovf    (arith_ovf)
   );

   // Signed less-than from sign and overflow of A - B, zero-extended.
   assign less_out = {{(W-1){1'b0}}, arith_neg ^ arith_ovf};

   alu_shifter #(.W(W), .AMT_W(AMT_W), .LEFT(1'b1), .ARITH(1'b0),
                 .STAGED(STAGED_SHIFT)) u_sll (
      .din (op_b), .amt (op_a[AMT_W-1:0]), .dout (sh_left)
   );

   alu_shifter #(.W(W), .AMT_W(AMT_W), .LEFT(1'b0), .ARITH(1'b0),
                 .STAGED(STAGED_SHIFT)) u_srl (
      .din (op_b), .amt (op_a[AMT_W-1:0]), .dout (sh_rlog)
   );

   alu_shifter #(.W(W), .AMT_W(AMT_W), .LEFT(1'b0), .ARITH(1'b1),
                 .STAGED(STAGED_SHIFT)) u_sra (
      .din (op_b), .amt (op_a[AMT_W-1:0]), .dout (sh_rari)
   );

   always_comb begin
      case (skind)
         SH_LEFT: sh_out = sh_left;
         SH_RLOG: sh_out = sh_rlog;
         SH_RARI: sh_out = sh_rari;
         default: sh_out = '0;
      endcase
   end

   always_comb begin
      case (src)
         SRC_ARITH: alu_result = arith_out;
         SRC_LESS:  alu_result = less_out;
         SRC_SHIFT: alu_result = sh_out;
         SRC_BITS:  alu_result = bits_out;
         default:   alu_result = '0;
      endcase
   end

   assign result_zero = ~|alu_result;

endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk #(
   parameter int W = 32
) (
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [3:0]   alu_op,
   input logic [W-1:0] alu_result,
   input logic         result_zero
);
   always_comb begin
      // R4
      less_width_chk: assert (alu_op != 4'b0111 || alu_result[W-1:1] == '0);
      // R4
      less_value_chk: assert (alu_op != 4'b0111 ||
                              alu_result[0] == ($signed(op_a) < $signed(op_b)));
      // R3
      sub_inverse_chk: assert (alu_op != 4'b0110 || alu_result + op_b == op_a);
      // R9
      unused_code_chk: assert (alu_op <= 4'b1000 || (alu_result == '0 && result_zero));
      // R10
      zero_flag_chk: assert (!result_zero || alu_result == '0);
      // R8
      shift_zero_chk: assert (!((alu_op == 4'b0100 || alu_op == 4'b0101 ||
                                 alu_op == 4'b1000) && op_a[4:0] == 5'd0) ||
                              alu_result == op_b);
   end
endmodule

bind rv_alu rv_alu_chk #(.W(W)) u_rv_alu_chk (
   .op_a        (op_a),
   .op_b        (op_b),
   .alu_op      (alu_op),
   .alu_result  (alu_result),
   .result_zero (result_zero)
);

// File: tb/tb_rv_alu.sv
module tb_rv_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [3:0]  alu_op = '0;
   logic [31:0] alu_result;
   logic        result_zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rv_alu dut (
      .op_a        (op_a),
      .op_b        (op_b),
      .alu_op      (alu_op),
      .alu_result  (alu_result),
      .result_zero (result_zero)
   );

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [3:0] op);
      longint sa, sb, acc;
      int     n;
      logic [31:0] r;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      n  = int'(a[4:0]);
      r  = '0;
      case (op)
         4'd0: r = a & b;
         4'd1: r = a | b;
         4'd3: r = a ^ b;
         4'd2: begin acc = sa + sb; r = acc[31:0]; end
         4'd6: begin acc = sa - sb; r = acc[31:0]; end
         4'd7: r = (sa < sb) ? 32'd1 : 32'd0;
         4'd4: for (int i = 0; i < 32; i++) r[i] = (i >= n) ? b[i-n] : 1'b0;
         4'd5: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : 1'b0;
         4'd8: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : b[31];
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag(input logic [31:0] a, input logic [3:0] op);
      case (op)
         4'd0, 4'd1, 4'd3: return "R1";
         4'd2: return "R2";
         4'd6: return "R3";
         4'd7: return "R4";
         4'd4: return (a[4:0] == 0) ? "R8" : "R5";
         4'd5: return (a[4:0] == 0) ? "R8" : "R6";
         4'd8: return (a[4:0] == 0) ? "R8" : "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
      logic [31:0] exp_r;
      logic        exp_z;
      @(posedge clk);
      op_a   = a;
      op_b   = b;
      alu_op = op;
      exp_r  = model(a, b, op);
      exp_z  = (exp_r == 32'd0);
      @(negedge clk);
      checks++;
      if (alu_result !== exp_r) begin
         errors++;
         $display("FAIL %s op=%b a=%h b=%h: actual %h expected %h",
                  tag(a, op), op, a, b, alu_result, exp_r);
      end
      checks++;
      if (result_zero !== exp_z) begin
         errors++;
         // R10
         $display("FAIL R10 op=%b a=%h b=%h: actual %b expected %b",
                  op, a, b, result_zero, exp_z);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Idle state: all-zero inputs give AND of zeros, zero flag set (R1, R10)
      apply(32'h0, 32'h0, 4'b0000);
      // R1 bitwise patterns, including disjoint masks giving zero
      apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000);
      apply(32'hAAAA_0000, 32'h0000_5555, 4'b0000);
      apply(32'hAAAA_0000, 32'h0000_5555, 4'b0001);
      apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0011);
      apply(32'h1234_5678, 32'hFFFF_0000, 4'b0011);
      // R2 addition with wrap
      apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
      apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
      // R3 subtraction, including self-cancel
      apply(32'h0000_0005, 32'h0000_0007, 4'b0110);
      apply(32'h1357_9BDF, 32'h1357_9BDF, 4'b0110);
      apply(32'h8000_0000, 32'h0000_0001, 4'b0110);
      // R4 less-than with overflow corners
      apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
      apply(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);
      apply(32'h0000_0003, 32'h0000_0003, 4'b0111);
      apply(32'h0000_0002, 32'h0000_0003, 4'b0111);
      // R5 / R6 / R7 shifts with upper A bits set, and R8 zero amount
      apply(32'hFFFF_FFE4, 32'h8000_0001, 4'b0100);
      apply(32'h0000_001F, 32'h0000_0002, 4'b0100);
      apply(32'hABCD_E01F, 32'h8000_0000, 4'b0101);
      apply(32'h0000_0004, 32'h8765_4321, 4'b0101);
      apply(32'h0000_001F, 32'h8000_0000, 4'b1000);
      apply(32'h0000_0008, 32'h7654_3210, 4'b1000);
      apply(32'hFFFF_FFE0, 32'hC001_D00D, 4'b0100);
      apply(32'h0000_0020, 32'hC001_D00D, 4'b0101);
      apply(32'h1234_5660, 32'hC001_D00D, 4'b1000);
      // R9 unused codes
      for (int c = 9; c < 16; c++) apply(32'hFFFF_FFFF, 32'h1234_5678, 4'(c));
      // Random sweep across every code
      for (int i = 0; i < 400; i++) apply($urandom, $urandom, 4'($urandom_range(0, 15)));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule